// File: doc/BRIEF.md
# Scanner Pixel Packer

This block sits between a scanner's one-bit video comparator and a DMA engine. Each sample-and-hold strobe carries one pixel. The pixel comes either from the comparator or from an external bypass input, and it can be inverted. Pixels taken while the active-window qualifier is high are packed least significant bit first into a 16-bit word. A completed word moves to a one-word holding buffer, which raises a request to the DMA engine and keeps it high until the engine acknowledges. A software read port shows the word being assembled.

Three pixel-source modes are decoded from three control bits: a bypass bit, a port mode-select bit and a port enable bit. In output-bypass mode the block drives an external pin with the inverse of the comparator value captured on the latest strobe, so an external circuit can use it for edge processing. When the window closes on a partly filled word, that word is flushed to the buffer with its unfilled bits at zero. If a word completes while the buffer is still waiting for the DMA engine, the new word is dropped and a sticky overrun flag is set.

Top module: `scan_bitmap_packer`

## Requirements
- R1: After reset, dma_req is 0, overrun is 0, shf_data is all zero and byp_oe is 0.
- R2: With cfg_bypass=0 and cfg_msel=0 (normal mode), cmp_pixel is the pixel source and byp_oe is 0.
- R3: With cfg_bypass=1, cfg_msel=1 and cfg_pen=0 (input bypass), byp_in is the pixel source, cmp_pixel has no effect and byp_oe is 0.
- R4: With cfg_bypass=0, cfg_msel=1 and cfg_pen=1 (output bypass), cmp_pixel is the pixel source and byp_oe equals scan_en. byp_out is the inverse of the cmp_pixel value sampled at the latest snh leading edge, and it is updated in the cycle after that edge.
- R5: Any other combination of the three control bits behaves as normal mode: the comparator is the source and byp_oe is 0.
- R6: With cfg_invert=1, every pixel is complemented before it enters the shifter.
- R7: The n-th pixel taken in a word lands in bit n-1 (the first pixel in bit 0). shf_data shows the bits taken so far, and the bits not yet filled read as zero.
- R8: A pixel is taken only on an snh leading edge, meaning snh is 1 at a clock edge and was 0 at the previous clock edge, and only while win_active is 1. Holding snh high takes only one pixel. Strobes while win_active is 0 change nothing.
- R9: On the 16th pixel, the word moves to the holding buffer. dma_req is 1 and dma_data holds the word from the following cycle, and shf_data returns to zero.
- R10: While dma_req is 1 and dma_ack is 0, dma_req and dma_data hold their values. One cycle with dma_ack=1 empties the buffer.
- R11: If a word completes while the buffer is full and dma_ack is 0, the new word is dropped, the buffered word and dma_data are unchanged, and overrun becomes 1 and stays 1 until reset.
- R12: When win_active falls with 1 to 15 pixels in the shifter, the partial word, with its upper bits zero, moves to the buffer. A window that closes with no pixels pushes nothing.
- R13: When scan_en is 0, byp_oe is 0 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bypass | input | 1 | Bypass control bit |
| cfg_msel | input | 1 | Port mode-select bit |
| cfg_pen | input | 1 | Port enable bit |
| cfg_invert | input | 1 | Invert pixels before packing |
| scan_en | input | 1 | Scanner enabled; gates the bypass pin driver |
| cmp_pixel | input | 1 | Comparator result |
| byp_in | input | 1 | External pixel input (input-bypass mode) |
| snh | input | 1 | Sample-and-hold strobe, level |
| win_active | input | 1 | Active video window qualifier |
| byp_out | output | 1 | Inverted last sampled comparator value |
| byp_oe | output | 1 | Drive enable for the bypass pin |
| dma_req | output | 1 | Buffered word valid / DMA request |
| dma_ack | input | 1 | DMA acknowledge; one high cycle empties the buffer |
| dma_data | output | 16 | Buffered bitmap word |
| shf_data | output | 16 | Software view of the word being assembled |
| overrun | output | 1 | Sticky: a completed word was dropped |

## Verification
The strobe edge detector and the bit counter are the internal state most likely to go wrong. A wrong count shows at the ports as a pixel in the wrong bit of shf_data after the very next strobe, and as a dma_req that rises one pixel early or late. A stale edge register shows up as a repeated pixel as soon as snh is held high. A wrong buffer state shows within one word: either as a dma_req that drops without an acknowledge, or as an overrun flag set while the buffer was empty. The three source modes each use a complementary comparator and bypass pattern, so choosing the wrong source inverts every bit of the next word.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [1:0] {
        SRC_NORMAL  = 2'd0,
        SRC_IN_BYP  = 2'd1,
        SRC_OUT_BYP = 2'd2
    } src_mode_e;

    // Map the three control bits to a pixel-source mode; unlisted codes fall back to normal.
    function automatic src_mode_e decode_src(input logic byp, input logic msel, input logic pen);
        if (!byp && msel && pen)
            return SRC_OUT_BYP;
        if (byp && msel && !pen)
            return SRC_IN_BYP;
        return SRC_NORMAL;
    endfunction

endpackage

// File: rtl/scan_pixel_src.sv
module scan_pixel_src
    import scan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_bypass,
    input  logic cfg_msel,
    input  logic cfg_pen,
    input  logic cfg_invert,
    input  logic scan_en,
    input  logic cmp_pixel,
    input  logic byp_in,
    input  logic snh,
    output logic pix_val,
    output logic pix_stb,
    output logic byp_out,
    output logic byp_oe
);

    typedef struct packed {
        logic snh;
        logic last;
    } src_st_t;

    src_st_t   s_d, s_q;
    src_mode_e mode;

    always_comb begin
        s_d     = s_q;
        mode    = decode_src(cfg_bypass, cfg_msel, cfg_pen);
        pix_stb = snh && !s_q.snh;
        s_d.snh = snh;
        if (pix_stb)
            s_d.last = cmp_pixel;
        pix_val = ((mode == SRC_IN_BYP) ? byp_in : cmp_pixel) ^ cfg_invert;
        byp_oe  = (mode == SRC_OUT_BYP) && scan_en;
        byp_out = !s_q.last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    // R4: bypass pin carries the inverse of the comparator captured on the last leading edge
    a_r4_byp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        pix_stb |=> (byp_out == !$past(cmp_pixel)));

    // R8: a held strobe produces no second edge
    a_r8_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        pix_stb |=> !pix_stb);

endmodule

// File: rtl/scan_shift_pack.sv
module scan_shift_pack #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_val,
    input  logic              pix_stb,
    input  logic              win_active,
    output logic [WORD_W-1:0] shf_data,
    output logic              push,
    output logic [WORD_W-1:0] push_data
);

    localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] shf;
        logic [IDX_W-1:0]  cnt;
        logic              win;
    } pack_st_t;

    pack_st_t          s_d, s_q;
    logic [WORD_W-1:0] filled;

    always_comb begin
        s_d       = s_q;
        s_d.win   = win_active;
        push      = 1'b0;
        push_data = '0;
        filled    = s_q.shf;
        filled[s_q.cnt] = pix_val;
        if (pix_stb && win_active) begin
            if (s_q.cnt == LAST_IDX) begin
                push      = 1'b1;
                push_data = filled;
                s_d.shf   = '0;
                s_d.cnt   = '0;
            end else begin
                s_d.shf = filled;
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (!win_active && s_q.win && (s_q.cnt != '0)) begin
            push      = 1'b1;
            push_data = s_q.shf;
            s_d.shf   = '0;
            s_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign shf_data = s_q.shf;

    // R8: nothing moves while the window is closed and was closed before
    a_r8_idle_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_active && !s_q.win) |=> $stable(shf_data));

    // R9: a pushed word leaves an empty shifter behind
    a_r9_push_clears: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (shf_data == '0));

endmodule

// File: rtl/scan_word_buf.sv
module scan_word_buf #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              dma_ack,
    output logic              dma_req,
    output logic [WORD_W-1:0] dma_data,
    output logic              overrun
);

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
        logic              ovr;
    } buf_st_t;

    buf_st_t s_d, s_q;
    logic    room;

    always_comb begin
        s_d       = s_q;
        room      = !s_q.valid || dma_ack;
        s_d.valid = s_q.valid && !dma_ack;
        if (push) begin
            if (room) begin
                s_d.valid = 1'b1;
                s_d.data  = push_data;
            end else begin
                s_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign dma_req  = s_q.valid;
    assign dma_data = s_q.data;
    assign overrun  = s_q.ovr;

    // R10: an unacknowledged request and its word stay put
    a_r10_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack) |=> (dma_req && $stable(dma_data)));

    // R11: a word arriving at a full, unacknowledged buffer raises overrun
    a_r11_set_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        (push && dma_req && !dma_ack) |=> overrun);

    // R11: overrun never clears on its own
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

// File: rtl/scan_bitmap_packer.sv
module scan_bitmap_packer #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bypass,
    input  logic              cfg_msel,
    input  logic              cfg_pen,
    input  logic              cfg_invert,
    input  logic              scan_en,
    input  logic              cmp_pixel,
    input  logic              byp_in,
    input  logic              snh,
    input  logic              win_active,
    output logic              byp_out,
    output logic              byp_oe,
    output logic              dma_req,
    input  logic              dma_ack,
    output logic [WORD_W-1:0] dma_data,
    output logic [WORD_W-1:0] shf_data,
    output logic              overrun
);

    logic              pix_val;
    logic              pix_stb;
    logic              push;
    logic [WORD_W-1:0] push_data;

    scan_pixel_src i_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_bypass (cfg_bypass),
        .cfg_msel   (cfg_msel),
        .cfg_pen    (cfg_pen),
        .cfg_invert (cfg_invert),
        .scan_en    (scan_en),
        .cmp_pixel  (cmp_pixel),
        .byp_in     (byp_in),
        .snh        (snh),
        .pix_val    (pix_val),
        .pix_stb    (pix_stb),
        .byp_out    (byp_out),
        .byp_oe     (byp_oe)
    );

    scan_shift_pack #(.WORD_W(WORD_W)) i_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_val    (pix_val),
        .pix_stb    (pix_stb),
        .win_active (win_active),
        .shf_data   (shf_data),
        .push       (push),
        .push_data  (push_data)
    );

    scan_word_buf #(.WORD_W(WORD_W)) i_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_data  (push_data),
        .dma_ack    (dma_ack),
        .dma_req    (dma_req),
        .dma_data   (dma_data),
        .overrun    (overrun)
    );

    // R13: the pin driver is released whenever the scanner is off
    a_r13_pin_off: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |-> !byp_oe);

endmodule

// File: tb/test_scan_bitmap_packer.sv
module test_scan_bitmap_packer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bypass = 1'b0, cfg_msel = 1'b0, cfg_pen = 1'b0, cfg_invert = 1'b0;
    logic        scan_en = 1'b0, cmp_pixel = 1'b0, byp_in = 1'b0, snh = 1'b0;
    logic        win_active = 1'b0, dma_ack = 1'b0;
    logic        byp_out, byp_oe, dma_req, overrun;
    logic [15:0] dma_data, shf_data;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_bitmap_packer i_scan_bitmap_packer (
        .clk(clk), .rst_n(rst_n), .cfg_bypass(cfg_bypass), .cfg_msel(cfg_msel),
        .cfg_pen(cfg_pen), .cfg_invert(cfg_invert), .scan_en(scan_en),
        .cmp_pixel(cmp_pixel), .byp_in(byp_in), .snh(snh), .win_active(win_active),
        .byp_out(byp_out), .byp_oe(byp_oe), .dma_req(dma_req), .dma_ack(dma_ack),
        .dma_data(dma_data), .shf_data(shf_data), .overrun(overrun)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic b, input logic m, input logic p, input logic inv);
        @(negedge clk);
        cfg_bypass = b; cfg_msel = m; cfg_pen = p; cfg_invert = inv;
    endtask

    // one strobe: comparator value c, bypass value b
    task automatic pix(input logic c, input logic b);
        @(negedge clk);
        cmp_pixel = c; byp_in = b; snh = 1'b1;
        @(negedge clk);
        snh = 1'b0;
    endtask

    // sixteen pixels; the unused source carries the complement
    task automatic send_word(input logic [15:0] w, input logic via_byp);
        for (int i = 0; i < 16; i++) begin
            if (via_byp) pix(~w[i], w[i]);
            else         pix(w[i], ~w[i]);
        end
    endtask

    task automatic ack_word(input string req, input logic [15:0] exp);
        check(req, {31'd0, dma_req}, 32'd1);
        check(req, {16'd0, dma_data}, {16'd0, exp});
        @(negedge clk); dma_ack = 1'b1;
        @(negedge clk); dma_ack = 1'b0;
        check("R10 ack empties buffer", {31'd0, dma_req}, 32'd0);
    endtask

    task automatic t_reset;
        check("R1 req", {31'd0, dma_req}, 32'd0);
        check("R1 overrun", {31'd0, overrun}, 32'd0);
        check("R1 shifter", {16'd0, shf_data}, 32'd0);
        check("R1 oe", {31'd0, byp_oe}, 32'd0);
    endtask

    task automatic t_normal;
        set_mode(1'b0, 1'b0, 1'b0, 1'b0);
        scan_en = 1'b1; win_active = 1'b1;
        pix(1'b1, 1'b0); pix(1'b1, 1'b0); pix(1'b0, 1'b1);
        check("R7 lsb first partial", {16'd0, shf_data}, 32'h0003);
        check("R2 oe low", {31'd0, byp_oe}, 32'd0);
        for (int i = 3; i < 16; i++) pix(logic'((16'hA5C3 >> i) & 1), 1'b0);
        check("R9 shifter cleared", {16'd0, shf_data}, 32'd0);
        check("R9 req raised", {31'd0, dma_req}, 32'd1);
        repeat (3) @(negedge clk);
        check("R10 req held", {31'd0, dma_req}, 32'd1);
        ack_word("R2 R7 word", 16'hA5C3);
    endtask

    task automatic t_input_bypass;
        set_mode(1'b1, 1'b1, 1'b0, 1'b0);
        send_word(16'h6E19, 1'b1);
        check("R3 oe low", {31'd0, byp_oe}, 32'd0);
        ack_word("R3 bypass source", 16'h6E19);
    endtask

    task automatic t_invert;
        set_mode(1'b0, 1'b0, 1'b0, 1'b1);
        send_word(16'h1234, 1'b0);
        ack_word("R6 inverted word", 16'hEDCB);
        set_mode(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_output_bypass;
        set_mode(1'b0, 1'b1, 1'b1, 1'b0);
        pix(1'b1, 1'b0);
        check("R4 oe", {31'd0, byp_oe}, 32'd1);
        check("R4 pin after 1", {31'd0, byp_out}, 32'd0);
        pix(1'b0, 1'b0);
        check("R4 pin after 0", {31'd0, byp_out}, 32'd1);
        pix(1'b1, 1'b0);
        check("R4 pin after 1 again", {31'd0, byp_out}, 32'd0);
        check("R4 comparator feeds shifter", {16'd0, shf_data}, 32'h0005);
        @(negedge clk); win_active = 1'b0;
        @(negedge clk);
        ack_word("R12 partial flush", 16'h0005);
        @(negedge clk); win_active = 1'b1;
        @(negedge clk); win_active = 1'b0;
        @(negedge clk);
        check("R12 empty window no push", {31'd0, dma_req}, 32'd0);
        scan_en = 1'b0;
        #1 check("R13 oe off when disabled", {31'd0, byp_oe}, 32'd0);
        scan_en = 1'b1;
    endtask

    task automatic t_gating;
        set_mode(1'b0, 1'b0, 1'b0, 1'b0);
        win_active = 1'b0;
        pix(1'b1, 1'b1); pix(1'b1, 1'b1); pix(1'b1, 1'b1);
        check("R8 closed window shifter", {16'd0, shf_data}, 32'd0);
        check("R8 closed window req", {31'd0, dma_req}, 32'd0);
        @(negedge clk); win_active = 1'b1; cmp_pixel = 1'b1; snh = 1'b1;
        repeat (4) @(negedge clk);
        snh = 1'b0;
        @(negedge clk);
        check("R8 held strobe one pixel", {16'd0, shf_data}, 32'h0001);
        pix(1'b0, 1'b1); pix(1'b1, 1'b0);
        check("R8 R7 next pixels", {16'd0, shf_data}, 32'h0005);
        @(negedge clk); win_active = 1'b0;
        @(negedge clk);
        ack_word("R12 flush upper zero", 16'h0005);
    endtask

    task automatic t_overrun;
        set_mode(1'b0, 1'b0, 1'b0, 1'b0);
        win_active = 1'b1;
        send_word(16'h0F0F, 1'b0);
        check("R11 no overrun yet", {31'd0, overrun}, 32'd0);
        send_word(16'h3C3C, 1'b0);
        check("R11 overrun set", {31'd0, overrun}, 32'd1);
        check("R11 old word kept", {16'd0, dma_data}, 32'h0F0F);
        ack_word("R11 buffered word", 16'h0F0F);
        check("R11 overrun sticky", {31'd0, overrun}, 32'd1);
        send_word(16'h1111, 1'b0);
        ack_word("R9 word after overrun", 16'h1111);
    endtask

    task automatic t_odd_mode;
        set_mode(1'b1, 1'b0, 1'b1, 1'b0);
        pix(1'b1, 1'b0); pix(1'b0, 1'b1);
        check("R5 comparator source", {16'd0, shf_data}, 32'h0001);
        check("R5 oe low", {31'd0, byp_oe}, 32'd0);
        @(negedge clk); win_active = 1'b0;
        @(negedge clk);
        ack_word("R5 flushed", 16'h0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_normal;
        t_input_bypass;
        t_invert;
        t_output_bypass;
        t_gating;
        t_overrun;
        t_odd_mode;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule